// File: doc/BRIEF.md
# Keyed Watchdog Timer with Prescaler

This block is a supervisory timer. Software has to service it regularly. A 16-bit down counter is clocked through a prescaler that divides the master clock by one of four ratios. Each valid restart write reloads the counter. The reload value takes its top four bits from a programmable field and has every lower bit set. If the counter runs past zero, an overflow event fires. The counter then reloads itself, and up to three actions start, each with its own enable bit: a one-cycle reset request, a one-cycle interrupt pulse, and an active-low external pin held low for eight clocks.

Every register write must carry a key in its upper byte during the same bus cycle. A write without the key is dropped. This stops stray stores from disarming or reprogramming the timer. Reads need no key, and the key bits always read as zero. A status flag records an overflow, and reading it clears it.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, wdReset and wdIrq are 0 and extOvfN is 1. The register reads are: address 0 reads 0x0000, address 1 reads 0x003C, address 3 reads 0x0000, and address 4 reads 0xFFFF.
- R2: Register map. Address 0 is the mode register: bit 0 run enable, bit 1 reset action, bit 2 interrupt action, bit 3 external action. Address 1 is the clock-mode register: bits 1:0 select the rate, bits 5:2 hold the reload high nibble. Address 2 is restart. Address 3 is status, with bit 0 the overflow flag. Address 4 reads the live counter. Reads need no key, and the key bits read as zero.
- R3: A write to address 0 needs 0x23 in bits 15:8, and a write to address 1 needs 0x37 there. A write without the correct key leaves the register unchanged.
- R4: Writing exactly 0x0C07 to address 2 loads the counter with {nibble, 12'hFFF} and clears the prescaler. Any other value written there has no effect.
- R5: While running, the counter decrements once every 8, 32, 128 or 1024 clocks for rate select 0, 1, 2 or 3.
- R6: While run enable is 0, the counter holds its value.
- R7: A tick that arrives when the counter is 0 is an overflow. The counter reloads to {nibble, 12'hFFF} on that same edge.
- R8: If the interrupt action is enabled, wdIrq is high for exactly the one cycle after the overflow edge.
- R9: If the reset action is enabled, wdReset is high for exactly the one cycle after the overflow edge.
- R10: If the external action is enabled, extOvfN is low for exactly 8 cycles, starting right after the overflow edge.
- R11: An overflow sets status bit 0. A read of address 3 returns the flag and then clears it.
- R12: An action whose enable bit is 0 leaves its output inactive across an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (clears status on read) |
| addr | input | 3 | Register address |
| wrData | input | 16 | Write data including key byte |
| rdData | output | 16 | Combinational read data |
| wdReset | output | 1 | Internal reset request pulse |
| wdIrq | output | 1 | Interrupt pulse |
| extOvfN | output | 1 | Active-low external overflow indication |

## Verification
The bench checks the exact edge where the counter leaves zero. If the overflow were off by one tick, or the reload skipped, the alarm would appear one prescaler period early or late, or the counter would read 0xFFFF instead of 0x0FFF. Each rate select is checked one clock before and one clock at its tick, so a miscounted divider fails. It writes wrong keys and a restart word off by one bit, which a loose key compare would accept and then change the mode or reload the counter. It also checks the external pulse at its ninth cycle, and it runs an overflow with all actions disabled, so a wrong pulse length or an ungated output is caught.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W  = 16;
  localparam int NIB_W  = 4;
  localparam int SEL_W  = 2;
  localparam int NSEL   = 1 << SEL_W;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int ACT_N  = 3;
  localparam int ACT_RST = 0;
  localparam int ACT_IRQ = 1;
  localparam int ACT_EXT = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE  = 3'd0,
    REG_CLK   = 3'd1,
    REG_RESTART = 3'd2,
    REG_STAT  = 3'd3,
    REG_CNT   = 3'd4
  } regAddr_t;

  // Strobes and settings from control to datapath
  typedef struct packed {
    logic             restart;
    logic             runEn;
    logic [ACT_N-1:0] actMask;
    logic [SEL_W-1:0] clkSel;
    logic [NIB_W-1:0] hiNib;
  } wdtCtl_t;

  // Feedback from datapath to control
  typedef struct packed {
    logic             ovf;
    logic [CNT_W-1:0] count;
  } wdtEvt_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter logic [7:0]        KEY_MODE     = 8'h23,
  parameter logic [7:0]        KEY_CLK      = 8'h37,
  parameter logic [DATA_W-1:0] RESTART_WORD = 16'h0C07
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  wdtEvt_t           evt,
  output wdtCtl_t           ctl
);
  localparam int KEY_LO = DATA_W - 8;

  logic             runEnQ;
  logic [ACT_N-1:0] actQ;
  logic [SEL_W-1:0] selQ;
  logic [NIB_W-1:0] nibQ;
  logic             ovfFlag;

  logic keyModeOk, keyClkOk, restartOk, statRead;

  always_comb begin
    keyModeOk = wrEn && (addr == REG_MODE) && (wrData[DATA_W-1:KEY_LO] == KEY_MODE);
    keyClkOk  = wrEn && (addr == REG_CLK)  && (wrData[DATA_W-1:KEY_LO] == KEY_CLK);
    restartOk = wrEn && (addr == REG_RESTART) && (wrData == RESTART_WORD);
    statRead  = rdEn && (addr == REG_STAT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEnQ <= 1'b0;
      actQ   <= '0;
    end else if (keyModeOk) begin
      runEnQ <= wrData[0];
      actQ   <= wrData[ACT_N:1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= '0;
      nibQ <= '1;
    end else if (keyClkOk) begin
      selQ <= wrData[SEL_W-1:0];
      nibQ <= wrData[SEL_W+NIB_W-1:SEL_W];
    end
  end

  // Overflow flag: a new event wins over a clearing read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ovfFlag <= 1'b0;
    else if (evt.ovf)   ovfFlag <= 1'b1;
    else if (statRead)  ovfFlag <= 1'b0;
  end

  always_comb begin
    ctl.restart = restartOk;
    ctl.runEn   = runEnQ;
    ctl.actMask = actQ;
    ctl.clkSel  = selQ;
    ctl.hiNib   = nibQ;
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      REG_MODE: rdData[ACT_N:0] = {actQ, runEnQ};
      REG_CLK:  rdData[SEL_W+NIB_W-1:0] = {nibQ, selQ};
      REG_STAT: rdData[0] = ovfFlag;
      REG_CNT:  rdData[CNT_W-1:0] = evt.count;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int unsigned DIV_SHIFT [NSEL] = '{3, 5, 7, 10},
  parameter int unsigned EXT_LEN = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  wdtCtl_t ctl,
  output wdtEvt_t evt,
  output logic    wdReset,
  output logic    wdIrq,
  output logic    extOvfN
);
  function automatic int maxShift();
    int m = 1;
    for (int i = 0; i < NSEL; i++)
      if (int'(DIV_SHIFT[i]) > m) m = int'(DIV_SHIFT[i]);
    return m;
  endfunction

  localparam int PRE_W = maxShift();
  localparam int LOW_W = CNT_W - NIB_W;
  localparam int EXT_W = $clog2(EXT_LEN + 1);

  logic [PRE_W-1:0] divLast [NSEL];
  logic [PRE_W-1:0] presc;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] reloadVal;
  logic [EXT_W-1:0] extCnt;
  logic             tick, ovfNow;

  for (genvar g = 0; g < NSEL; g++) begin : g_div
    assign divLast[g] = PRE_W'((64'd1 << DIV_SHIFT[g]) - 64'd1);
  end

  always_comb begin
    reloadVal = {ctl.hiNib, {LOW_W{1'b1}}};
    tick      = ctl.runEn && (presc >= divLast[ctl.clkSel]);
    ovfNow    = !ctl.restart && tick && (count == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc <= '0;
      count <= '1;
    end else if (ctl.restart) begin
      presc <= '0;
      count <= reloadVal;
    end else if (ctl.runEn) begin
      if (tick) begin
        presc <= '0;
        count <= (count == '0) ? reloadVal : count - 1'b1;
      end else begin
        presc <= presc + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdReset <= 1'b0;
      wdIrq   <= 1'b0;
      extCnt  <= '0;
    end else begin
      wdReset <= ovfNow && ctl.actMask[ACT_RST];
      wdIrq   <= ovfNow && ctl.actMask[ACT_IRQ];
      if (ovfNow && ctl.actMask[ACT_EXT]) extCnt <= EXT_W'(EXT_LEN);
      else if (extCnt != '0)              extCnt <= extCnt - 1'b1;
    end
  end

  always_comb begin
    extOvfN   = (extCnt == '0);
    evt.ovf   = ovfNow;
    evt.count = count;
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter logic [7:0]  KEY_MODE     = 8'h23,
  parameter logic [7:0]  KEY_CLK      = 8'h37,
  parameter logic [15:0] RESTART_WORD = 16'h0C07,
  parameter int unsigned EXT_LEN      = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [2:0]  addr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        wdReset,
  output logic        wdIrq,
  output logic        extOvfN
);
  wdtCtl_t ctlBus;
  wdtEvt_t evtBus;

  wdt_ctrl #(
    .KEY_MODE(KEY_MODE), .KEY_CLK(KEY_CLK), .RESTART_WORD(RESTART_WORD)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .evt(evtBus), .ctl(ctlBus)
  );

  wdt_datapath #(
    .EXT_LEN(EXT_LEN)
  ) uData (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .evt(evtBus),
    .wdReset(wdReset), .wdIrq(wdIrq), .extOvfN(extOvfN)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter logic [7:0]  KEY_MODE = 8'h23,
  parameter int unsigned EXT_LEN  = 8
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [2:0]  addr,
  input logic [15:0] wrData,
  input wdtCtl_t     ctl,
  input wdtEvt_t     evt,
  input logic        wdReset,
  input logic        wdIrq,
  input logic        extOvfN
);
  localparam int LOW_W = CNT_W - NIB_W;
  logic [7:0] lowLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         lowLen <= '0;
    else if (!extOvfN) lowLen <= lowLen + 1'b1;
    else               lowLen <= '0;
  end

  AST_BAD_KEY_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_MODE && wrData[15:8] != KEY_MODE) |=> $stable({ctl.runEn, ctl.actMask})); // R3
  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.restart |=> evt.count == {$past(ctl.hiNib), {LOW_W{1'b1}}}); // R4
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.runEn && !ctl.restart) |=> $stable(evt.count)); // R6
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wdIrq |=> !wdIrq); // R8
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |=> !wdReset); // R9
  AST_EXT_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extOvfN) |-> lowLen == 8'(EXT_LEN)); // R10
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdIrq) |-> $past(ctl.actMask[ACT_IRQ])); // R12
endmodule

bind keyed_watchdog wdt_checker #(.KEY_MODE(KEY_MODE), .EXT_LEN(EXT_LEN)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .ctl(ctlBus), .evt(evtBus), .wdReset(wdReset), .wdIrq(wdIrq), .extOvfN(extOvfN)
);

// File: tb/tb_keyed_watchdog.sv
`timescale 1ns/1ps
module tb_keyed_watchdog;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        wdReset, wdIrq, extOvfN;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  keyed_watchdog dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .wdReset(wdReset), .wdIrq(wdIrq), .extOvfN(extOvfN)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #0.5 d = rdData;
  endtask

  task automatic testReset();
    logic [15:0] v;
    chk("R1 wdReset", {15'b0, wdReset}, 16'h0);
    chk("R1 wdIrq", {15'b0, wdIrq}, 16'h0);
    chk("R1 extOvfN", {15'b0, extOvfN}, 16'h1);
    rd(3'd0, v); chk("R1 mode", v, 16'h0000);
    rd(3'd1, v); chk("R1 clkmode", v, 16'h003C);
    rd(3'd3, v); chk("R1 status", v, 16'h0000);
    rd(3'd4, v); chk("R1 count", v, 16'hFFFF);
  endtask

  task automatic testKeys();
    logic [15:0] v;
    wr(3'd0, 16'h230E);
    rd(3'd0, v); chk("R2 mode readback key zero", v, 16'h000E);
    wr(3'd0, 16'h2201);
    rd(3'd0, v); chk("R3 mode bad key ignored", v, 16'h000E);
    wr(3'd1, 16'h3601);
    rd(3'd1, v); chk("R3 clkmode bad key ignored", v, 16'h003C);
    wr(3'd1, 16'h3735);
    rd(3'd1, v); chk("R2 clkmode readback", v, 16'h0035);
    wr(3'd1, 16'h373C);
  endtask

  task automatic testHold();
    logic [15:0] v;
    wr(3'd2, 16'h0C07);
    repeat (100) @(negedge clk);
    rd(3'd4, v); chk("R6 count holds while disabled", v, 16'hFFFF);
  endtask

  task automatic testRate(input int sel, input int div);
    logic [15:0] v;
    wr(3'd1, 16'h373C | 16'(sel));
    wr(3'd2, 16'h0C07);
    repeat (3 * div - 1) @(negedge clk);
    peek(3'd4, v); chk($sformatf("R5 sel%0d before tick", sel), v, 16'hFFFD);
    @(negedge clk);
    peek(3'd4, v); chk($sformatf("R5 sel%0d at tick", sel), v, 16'hFFFC);
  endtask

  task automatic testBadRestart();
    logic [15:0] v;
    wr(3'd1, 16'h373C);
    wr(3'd2, 16'h0C07);
    repeat (80) @(negedge clk);
    wr(3'd2, 16'h0C06);
    rd(3'd4, v); chk("R4 wrong restart word ignored", v, 16'hFFF5);
    wr(3'd2, 16'h0C07);
    rd(3'd4, v); chk("R4 restart reloads", v, 16'hFFFF);
  endtask

  task automatic testOverflow();
    logic [15:0] v;
    wr(3'd1, 16'h3700);
    wr(3'd0, 16'h230F);
    wr(3'd2, 16'h0C07);
    repeat (32767) @(negedge clk);
    peek(3'd4, v); chk("R7 count zero before overflow", v, 16'h0000);
    chk("R8 no irq before overflow", {15'b0, wdIrq}, 16'h0);
    @(negedge clk);
    peek(3'd4, v); chk("R7 reload after overflow", v, 16'h0FFF);
    chk("R8 irq pulse", {15'b0, wdIrq}, 16'h1);
    chk("R9 reset pulse", {15'b0, wdReset}, 16'h1);
    chk("R10 ext low cycle 1", {15'b0, extOvfN}, 16'h0);
    @(negedge clk);
    chk("R8 irq single cycle", {15'b0, wdIrq}, 16'h0);
    chk("R9 reset single cycle", {15'b0, wdReset}, 16'h0);
    for (int k = 2; k <= 7; k++) begin
      chk($sformatf("R10 ext low cycle %0d", k), {15'b0, extOvfN}, 16'h0);
      @(negedge clk);
    end
    chk("R10 ext low cycle 8", {15'b0, extOvfN}, 16'h0);
    @(negedge clk);
    chk("R10 ext released after 8", {15'b0, extOvfN}, 16'h1);
    rd(3'd3, v); chk("R11 status set", v, 16'h0001);
    rd(3'd3, v); chk("R11 status cleared by read", v, 16'h0000);
  endtask

  task automatic testMasked();
    logic [15:0] v;
    int bad = 0;
    wr(3'd0, 16'h2301);
    wr(3'd2, 16'h0C07);
    for (int k = 0; k < 32768; k++) begin
      @(negedge clk);
      if (wdIrq || wdReset || !extOvfN) bad++;
    end
    peek(3'd4, v); chk("R7 reload with actions off", v, 16'h0FFF);
    chk("R12 outputs stayed inactive", 16'(bad), 16'h0);
    rd(3'd3, v); chk("R11 status set with actions off", v, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testKeys();
    testHold();
    wr(3'd0, 16'h2301);
    testRate(0, 8);
    testRate(1, 32);
    testRate(2, 128);
    testRate(3, 1024);
    testBadRestart();
    testOverflow();
    testMasked();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule